// File: doc/BRIEF.md
# Packed Palette RAM with RGB Expander

This block holds the colour palette of an LCD controller. Software sees the palette as a window of 128 bus words. Each 32-bit word carries two 16-bit colour entries, so the window describes 256 colours. The words are stored exactly as written, and a bus read of the window returns them unchanged.

Every write into the window also unpacks both 16-bit entries. Each 5-bit red, green and blue field is widened to 8 bits. The two resulting 24-bit colours go into a separate lookup table in the same clock edge. A pixel pipeline reads that table through its own synchronous port, indexed by an 8-bit colour number, and gets the colour one cycle later. The bus side and the pixel side never contend. Conversion to a display-specific pixel format happens downstream of this block.

Top module: `lcd_palette_ram`

## Requirements
- R1: After a synchronous active-low reset, every stored bus word reads as zero and every lookup-table entry returns zero.
- R2: The window covers byte offsets 0x200 to 0x3FF. The word index is (offset - 0x200) >> 2, so offset bits [1:0] are ignored.
- R3: A write to an offset outside the window changes neither the stored words nor the lookup table. A read outside the window returns zero.
- R4: A bus read inside the window returns the word last written there, all 32 bits including bits 15 and 31, in `bus_rdata` one cycle after `bus_rd` is sampled.
- R5: Bits [15:0] of word n form colour entry 2n. Bits [31:16] of word n form colour entry 2n+1.
- R6: Within an entry, red is bits [4:0], green is bits [9:5] and blue is bits [14:10]. Each channel becomes 8 bits as {field, 3'b000}. The lookup output is {red, green, blue}, with red in bits [23:16] and blue in bits [7:0].
- R7: Bit 15 of each entry, the intensity bit, has no effect on the lookup-table colour.
- R8: A single bus write updates both of its lookup entries on the same clock edge. A lookup of either index issued in the next cycle returns the new colour.
- R9: The lookup port has one cycle of latency. `lut_rgb` shows the entry for the index sampled at the previous edge, and it does not change between edges when `lut_idx` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_addr | input | 12 | Bus byte offset |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Bus read data, registered |
| lut_idx | input | 8 | Pixel-side colour index |
| lut_rgb | output | 24 | Pixel-side colour {R,G,B}, registered |

## Verification
The unpacking is tried with three kinds of entry. Single-channel entries (red only, green only, blue only) show whether fields are swapped or misplaced within the 24-bit output. Entries with the intensity bit set, alone or together with all channels at full scale, show whether that bit leaks into the colour while still reading back on the bus. Words whose two halves differ show whether the low and high half are placed at 2n and 2n+1. A full sweep writes a distinct pattern to all 128 words and checks all 256 colours and all raw words. Edge offsets (0x1FC, 0x200, 0x3FC, 0x400), offsets with low bits set, and lookups issued directly after a write cover the window decode and the same-edge update of both entries.

// File: rtl/lcdpal_pkg.sv
// Package: shared sizes and types for the packed palette RAM.
// Assumes two colour entries per bus word and three equal-width channels.
package lcdpal_pkg;
    localparam int ENTRY_W  = 16;  // packed colour entry width
    localparam int CH_IN_W  = 5;   // stored channel width
    localparam int CH_OUT_W = 8;   // expanded channel width
    localparam int RGB_W    = 3 * CH_OUT_W;
    localparam int PER_WORD = 2;   // entries per bus word

    typedef struct packed {
        logic [CH_OUT_W-1:0] red;
        logic [CH_OUT_W-1:0] grn;
        logic [CH_OUT_W-1:0] blu;
    } rgb_t;
endpackage

// File: rtl/lcdpal_win_dec.sv
// Window decoder: turns a bus byte offset into a hit flag and a word index.
// Assumes BASE is word aligned and the window fits in the address space.
module lcdpal_win_dec #(
    parameter int          ADDR_W = 12,
    parameter logic [11:0] BASE   = 12'h200,
    parameter int          WORDS  = 128,
    localparam int         WIDX_W = $clog2(WORDS)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [WIDX_W-1:0] widx
);
    localparam logic [ADDR_W:0] WIN_LO = {1'b0, BASE[ADDR_W-1:0]};
    localparam logic [ADDR_W:0] WIN_HI = WIN_LO + (ADDR_W+1)'(WORDS * 4);

    logic [ADDR_W-1:0] rel;

    // Range check and word index extraction (byte offset bits dropped).
    always_comb begin
        hit  = ({1'b0, addr} >= WIN_LO) && ({1'b0, addr} < WIN_HI);
        rel  = addr - BASE[ADDR_W-1:0];
        widx = rel[WIDX_W+1:2];
    end
endmodule

// File: rtl/lcdpal_raw_store.sv
// Raw word store: keeps bus words exactly as written and serves bus reads.
// Assumes the caller qualifies write/read with the window hit; a read
// outside the window (rd_hit low while rd_en high) returns zero.
module lcdpal_raw_store #(
    parameter int  WORDS  = 128,
    parameter int  DATA_W = 32,
    localparam int WIDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [WIDX_W-1:0] widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_en,
    input  logic              rd_hit,
    input  logic [WIDX_W-1:0] ridx,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [WORDS];

    // Store update: clear on reset, otherwise take the addressed word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '0;
        end else if (we) begin
            mem[widx] <= wdata;
        end
    end

    // Read register: returns the stored word, or zero outside the window.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_hit ? mem[ridx] : '0;
    end

    // R4: a written word is held verbatim.
    a_r4_word_kept: assert property (@(posedge clk) disable iff (!rst_n)
        $past(we) && $past(rst_n) |-> mem[$past(widx)] == $past(wdata));
endmodule

// File: rtl/lcdpal_expand.sv
// Expander: splits a bus word into its packed entries and widens each
// 5-bit channel to 8 bits with zero fill. The intensity bit is dropped.
module lcdpal_expand
    import lcdpal_pkg::*;
#(
    parameter int DATA_W = ENTRY_W * PER_WORD
) (
    input  logic [DATA_W-1:0] word,
    output rgb_t              rgb [PER_WORD]
);
    generate
        for (genvar h = 0; h < PER_WORD; h++) begin : g_half
            logic [ENTRY_W-1:0] ent;
            // Pick the entry and widen each channel.
            always_comb begin
                ent        = word[h*ENTRY_W +: ENTRY_W];
                rgb[h].red = {ent[0*CH_IN_W +: CH_IN_W], (CH_OUT_W-CH_IN_W)'(0)};
                rgb[h].grn = {ent[1*CH_IN_W +: CH_IN_W], (CH_OUT_W-CH_IN_W)'(0)};
                rgb[h].blu = {ent[2*CH_IN_W +: CH_IN_W], (CH_OUT_W-CH_IN_W)'(0)};
            end
        end
    endgenerate
endmodule

// File: rtl/lcdpal_lut.sv
// Expanded colour table: both entries of a bus word are written on one
// edge; the pixel port reads synchronously (old data if same-edge write).
module lcdpal_lut
    import lcdpal_pkg::*;
#(
    parameter int  WORDS  = 128,
    localparam int DEPTH  = WORDS * PER_WORD,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int WIDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [WIDX_W-1:0] widx,
    input  rgb_t              wrgb [PER_WORD],
    input  logic [IDX_W-1:0]  ridx,
    output rgb_t              rrgb
);
    rgb_t mem [DEPTH];

    // Table update: clear on reset, else write both entries of the word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            for (int h = 0; h < PER_WORD; h++)
                mem[{widx, 1'(h)}] <= wrgb[h];
        end
    end

    // Pixel-side read register.
    always_ff @(posedge clk) begin
        if (!rst_n) rrgb <= '0;
        else        rrgb <= mem[ridx];
    end

    // R8: one write lands in both entries on the same edge.
    a_r8_pair_written: assert property (@(posedge clk) disable iff (!rst_n)
        $past(we) && $past(rst_n) |->
            mem[{$past(widx), 1'b0}] == $past(wrgb[0]) &&
            mem[{$past(widx), 1'b1}] == $past(wrgb[1]));
endmodule

// File: rtl/lcd_palette_ram.sv
// Top: packed palette RAM. Bus writes in the window store the raw word and
// the two expanded colours; the pixel port reads the expanded table.
// Assumes single-beat bus accesses with one-cycle registered read data.
module lcd_palette_ram
    import lcdpal_pkg::*;
#(
    parameter int          ADDR_W = 12,
    parameter logic [11:0] BASE   = 12'h200,
    parameter int          WORDS  = 128,
    localparam int         DATA_W = ENTRY_W * PER_WORD,
    localparam int         IDX_W  = $clog2(WORDS * PER_WORD),
    localparam int         WIDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [IDX_W-1:0]  lut_idx,
    output logic [RGB_W-1:0]  lut_rgb
);
    logic              hit;
    logic [WIDX_W-1:0] widx;
    logic              wr_hit;
    rgb_t              exp_rgb [PER_WORD];
    rgb_t              rd_rgb;

    lcdpal_win_dec #(.ADDR_W(ADDR_W), .BASE(BASE), .WORDS(WORDS)) u_dec (
        .addr(bus_addr), .hit(hit), .widx(widx)
    );

    // Qualify the write strobe with the window hit.
    always_comb wr_hit = bus_wr && hit;

    lcdpal_raw_store #(.WORDS(WORDS), .DATA_W(DATA_W)) u_raw (
        .clk(clk), .rst_n(rst_n), .we(wr_hit), .widx(widx), .wdata(bus_wdata),
        .rd_en(bus_rd), .rd_hit(hit), .ridx(widx), .rdata(bus_rdata)
    );

    lcdpal_expand #(.DATA_W(DATA_W)) u_exp (
        .word(bus_wdata), .rgb(exp_rgb)
    );

    lcdpal_lut #(.WORDS(WORDS)) u_lut (
        .clk(clk), .rst_n(rst_n), .we(wr_hit), .widx(widx), .wrgb(exp_rgb),
        .ridx(lut_idx), .rrgb(rd_rgb)
    );

    // Flatten the colour struct onto the port.
    always_comb lut_rgb = rd_rgb;

    // R3: a read outside the window yields zero.
    a_r3_outside_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_rd) && !$past(hit) && $past(rst_n) |-> bus_rdata == '0);

    // R6: widened channels never carry bits in their fill positions.
    a_r6_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
        lut_rgb[2:0] == 3'b0 && lut_rgb[10:8] == 3'b0 && lut_rgb[18:16] == 3'b0);
endmodule

// File: tb/sim_lcd_palette_ram.sv
module sim_lcd_palette_ram;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  lut_idx = '0;
    logic [23:0] lut_rgb;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    lcd_palette_ram u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .lut_idx(lut_idx), .lut_rgb(lut_rgb)
    );

    // Independent model of the colour widening.
    function automatic logic [23:0] widen(input logic [15:0] e);
        return {e[4:0], 3'b000, e[9:5], 3'b000, e[14:10], 3'b000};
    endfunction

    function automatic logic [31:0] pattern(input int n);
        return {16'(n * 517 + 3), 16'(n * 9133 + 40961)};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_check(input logic [11:0] a, input logic [31:0] exp, input string req);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        check(req, bus_rdata, exp);
    endtask

    task automatic lut_check(input logic [7:0] i, input logic [23:0] exp, input string req);
        lut_idx = i;
        @(negedge clk);
        check(req, {8'h0, lut_rgb}, {8'h0, exp});
    endtask

    task automatic t_reset;
        bus_check(12'h200, 32'h0, "R1");
        bus_check(12'h3FC, 32'h0, "R1");
        lut_check(8'd0, 24'h0, "R1");
        lut_check(8'd255, 24'h0, "R1");
    endtask

    task automatic t_channels;  // R5 R6
        bus_write(12'h214, {16'h03E0, 16'h001F});
        lut_check(8'd10, 24'hF80000, "R5/R6 red low half");
        lut_check(8'd11, 24'h00F800, "R5/R6 green high half");
        bus_write(12'h218, {16'h0421, 16'h7C00});
        lut_check(8'd12, 24'h0000F8, "R6 blue");
        lut_check(8'd13, 24'h080808, "R6 lsb of each field");
    endtask

    task automatic t_intensity;  // R7 R4
        bus_write(12'h21C, 32'h8000_FFFF);
        lut_check(8'd14, 24'hF8F8F8, "R7 full with intensity");
        lut_check(8'd15, 24'h000000, "R7 intensity only");
        bus_check(12'h21C, 32'h8000_FFFF, "R4 raw bits kept");
    endtask

    task automatic t_next_cycle;  // R8
        bus_write(12'h240, {16'h1234, 16'h5678});
        lut_check(8'd33, widen(16'h1234), "R8 high entry next cycle");
        bus_write(12'h240, {16'h7FFF, 16'h0001});
        lut_check(8'd32, widen(16'h0001), "R8 low entry next cycle");
        lut_check(8'd33, 24'hF8F8F8, "R8 high entry same write");
    endtask

    task automatic t_latency;  // R9
        lut_check(8'd14, 24'hF8F8F8, "R9 first index");
        lut_idx = 8'd15;
        #1;
        check("R9 output held until edge", {8'h0, lut_rgb}, 32'h00F8F8F8);
        @(negedge clk);
        check("R9 new index after edge", {8'h0, lut_rgb}, 32'h0);
    endtask

    task automatic t_window;  // R2 R3
        bus_write(12'h200, 32'hAAAA_5555);
        bus_write(12'h3FC, 32'h1357_2468);
        bus_write(12'h1FC, 32'hFFFF_FFFF);
        bus_write(12'h400, 32'hFFFF_FFFF);
        bus_check(12'h1FC, 32'h0, "R3 below window reads zero");
        bus_check(12'h400, 32'h0, "R3 above window reads zero");
        bus_check(12'h200, 32'hAAAA_5555, "R3 first word untouched");
        bus_check(12'h3FC, 32'h1357_2468, "R3 last word untouched");
        lut_check(8'd254, widen(16'h2468), "R2 last word low");
        lut_check(8'd255, widen(16'h1357), "R2 last word high");
        lut_check(8'd0, widen(16'h5555), "R3 entry 0 untouched");
        bus_write(12'h207, 32'h0F0F_7001);
        bus_check(12'h204, 32'h0F0F_7001, "R2 low offset bits ignored");
        bus_check(12'h206, 32'h0F0F_7001, "R2 read low bits ignored");
        lut_check(8'd2, widen(16'h7001), "R2 entry from offset 0x207");
    endtask

    task automatic t_sweep;  // R4 R5 R6
        for (int n = 0; n < 128; n++) bus_write(12'(12'h200 + n * 4), pattern(n));
        for (int n = 0; n < 128; n++) begin
            logic [31:0] w;
            w = pattern(n);
            bus_check(12'(12'h200 + n * 4), w, "R4 sweep raw");
            lut_check(8'(2 * n), widen(w[15:0]), "R5 sweep low");
            lut_check(8'(2 * n + 1), widen(w[31:16]), "R5 sweep high");
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_channels();
        t_intensity();
        t_next_cycle();
        t_latency();
        t_window();
        t_sweep();
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule